// File: doc/BRIEF.md
# Low-Power Mode Sequencer for an 8-bit Microcontroller

This block controls the two sleep modes of a small 8-bit microcontroller core. Software writes a two-bit mode field. Bit 0 requests idle, where the CPU clock is gated and the peripherals keep running. Bit 1 requests power-down, where the oscillator enable is also dropped. If both bits are written together, power-down wins. The block then decides which events wake the core. In idle, any enabled pending interrupt wakes it. In power-down, only the enabled external interrupt lines selected by a parameter mask wake it. A hardware reset ends either mode.

While the core sleeps, the block forces the address-latch and program-store strobes to the level the mode requires. Both are held high in idle and low in power-down. Port 0 floats when code runs from external program memory and keeps its data when code runs from internal memory.

An interrupt wake from power-down restarts the oscillator. The CPU clock stays gated until the oscillator reports stable and a programmable settle count has run out. Every interrupt wake ends with a one-cycle resume pulse, so the core takes the interrupt vector first.

A hardware reset that ends idle does not stop execution at once. The core first runs for a window of two machine cycles. During that window internal RAM write strobes are blocked and port writes are not. After the window the reset sequence takes over.

States: `ST_RUN`, `ST_IDLE`, `ST_PD` (oscillator off), `ST_PD_WAKE` (waiting for the oscillator), `ST_PD_STAB` (settle count), `ST_RESUME` (resume pulse), `ST_RST_WIN` (RAM-write-blocked window), `ST_RESET` (core held in reset).

Transitions:
- RUN→PD on a write with bit 1 set.
- RUN→IDLE on a write with only bit 0 set.
- IDLE→RESUME on any enabled pending interrupt.
- IDLE→RST_WIN on `hw_rst`.
- PD→PD_WAKE on an enabled external interrupt.
- PD_WAKE→PD_STAB on `osc_stable`.
- PD_STAB→RESUME when the count reaches zero.
- RESUME→RUN after one cycle.
- RST_WIN→RESET when the window count reaches zero.
- RUN, PD, PD_WAKE, PD_STAB and RESUME go to RESET on `hw_rst`.
- RESET→RUN when `hw_rst` is released.

Top module: `lpm_ctrl`

## Requirements
- R1: After `rst_n` the block is in run: `cpu_clk_en`=1, `osc_en`=1, `mode_q`=0, `core_rst`=0, `resume_pulse`=0, and no pin is forced.
- R2: In run, a write with `pcon_wdata`=2'b01 enters idle on the next cycle: `cpu_clk_en`=0, `osc_en`=1, `mode_q`=2'b01 (bit 0 idle, bit 1 power-down).
- R3: In run, a write with bit 1 set enters power-down on the next cycle, even with bit 0 also set: `mode_q`=2'b10, `cpu_clk_en`=0, `osc_en`=0.
- R4: Idle is left on any interrupt with both `irq_pend` and `irq_en` set. A pending interrupt that is not enabled leaves the block in idle.
- R5: Power-down is left only on an enabled pending interrupt whose bit is set in `EXT_MASK`. Other enabled interrupts leave `osc_en`=0 and `mode_q`=2'b10.
- R6: On an external wake from power-down, `osc_en` goes high the next cycle and `cpu_clk_en` stays 0 while `osc_stable` is low. Once `osc_stable` is seen at a clock edge, `resume_pulse` appears after `stab_limit`+2 edges, counting that edge.
- R7: Each interrupt wake gives exactly one cycle of `resume_pulse`, with `cpu_clk_en`=1 and `mode_q` already 0.
- R8: In idle `ale_frc`=`psen_frc`=1 and `ale_lvl`=`psen_lvl`=1. In power-down, both forces are 1 and both levels are 0. In run, no force is applied.
- R9: `p0_float` equals `ext_prog` in idle and power-down, and is 0 in run.
- R10: `hw_rst` in idle opens a window of 2·`MC_CLKS` cycles. During the window `cpu_clk_en`=1, `ram_wr_block`=1, `ram_we`=0 even when `ram_we_req`=1, `mode_q`=0 and `core_rst`=0. `core_rst`=1 follows immediately after the window.
- R11: `hw_rst` in power-down or run gives `core_rst`=1 and `osc_en`=1 on the next cycle, without a window. Releasing `hw_rst` returns to run one cycle later with `core_rst`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| hw_rst | input | 1 | Hardware reset pin request, active high |
| pcon_we | input | 1 | Mode register write strobe |
| pcon_wdata | input | 2 | Mode write data: bit 0 idle, bit 1 power-down |
| irq_pend | input | N_IRQ | Interrupt pending lines |
| irq_en | input | N_IRQ | Interrupt enable lines |
| ext_prog | input | 1 | Code is running from external program memory |
| osc_stable | input | 1 | Oscillator reports a stable output |
| stab_limit | input | STAB_W | Settle count after the oscillator is stable |
| ram_we_req | input | 1 | RAM write strobe from the core |
| ram_we | output | 1 | RAM write strobe after blocking |
| ram_wr_block | output | 1 | RAM writes are blocked |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| mode_q | output | 2 | Current mode bits |
| resume_pulse | output | 1 | One-cycle pulse telling the core to take the interrupt vector |
| core_rst | output | 1 | Reset sequence in control of the core |
| ale_frc | output | 1 | Force the address-latch strobe |
| ale_lvl | output | 1 | Forced address-latch level |
| psen_frc | output | 1 | Force the program-store strobe |
| psen_lvl | output | 1 | Forced program-store level |
| p0_float | output | 1 | Port 0 drivers tri-stated |

## Verification
The bench builds the block with `MC_CLKS`=3, so the reset window is 6 cycles long. Every window cycle and the hand-over to `core_rst` can then be counted one by one. `EXT_MASK`=5'b00101 marks interrupt bits 0 and 2 as external, so bit 1 serves as an enabled but non-external source that must not wake power-down. `STAB_W`=4 with `stab_limit`=3 makes the wake-to-resume delay short, so it can be checked exactly on the cycle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    typedef enum logic [2:0] {
        ST_RUN,
        ST_IDLE,
        ST_PD,
        ST_PD_WAKE,
        ST_PD_STAB,
        ST_RESUME,
        ST_RST_WIN,
        ST_RESET
    } lpm_state_e;

    typedef enum logic [1:0] {
        PM_RUN,
        PM_IDLE,
        PM_PD
    } pin_mode_e;

    localparam int unsigned MODE_IDLE_BIT = 0;
    localparam int unsigned MODE_PD_BIT   = 1;
endpackage

// File: rtl/lpm_dncnt.sv
module lpm_dncnt #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         en,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (en && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/lpm_wake.sv
module lpm_wake #(
    parameter int unsigned          N_IRQ    = 5,
    parameter logic [N_IRQ-1:0]     EXT_MASK = 5'b00101
) (
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    output logic             any_wake,
    output logic             ext_wake
);
    logic [N_IRQ-1:0] live;
    logic [N_IRQ-1:0] live_ext;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_src
        assign live[i] = irq_pend[i] & irq_en[i];
        if (EXT_MASK[i]) begin : g_ext
            assign live_ext[i] = live[i];
        end else begin : g_int
            assign live_ext[i] = 1'b0;
        end
    end

    assign any_wake = |live;
    assign ext_wake = |live_ext;
endmodule

// File: rtl/lpm_pins.sv
module lpm_pins
    import lpm_pkg::*;
(
    input  pin_mode_e pin_mode,
    input  logic      ext_prog,
    output logic      ale_frc,
    output logic      ale_lvl,
    output logic      psen_frc,
    output logic      psen_lvl,
    output logic      p0_float
);
    always_comb begin
        ale_frc  = 1'b0;
        ale_lvl  = 1'b0;
        psen_frc = 1'b0;
        psen_lvl = 1'b0;
        p0_float = 1'b0;
        unique case (pin_mode)
            PM_IDLE: begin
                ale_frc  = 1'b1;
                ale_lvl  = 1'b1;
                psen_frc = 1'b1;
                psen_lvl = 1'b1;
                p0_float = ext_prog;
            end
            PM_PD: begin
                ale_frc  = 1'b1;
                psen_frc = 1'b1;
                p0_float = ext_prog;
            end
            default: begin
                p0_float = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_rst,
    input  logic       pcon_we,
    input  logic [1:0] pcon_wdata,
    input  logic       any_wake,
    input  logic       ext_wake,
    input  logic       osc_stable,
    input  logic       stab_zero,
    input  logic       win_zero,
    output lpm_state_e st,
    output logic       stab_load,
    output logic       stab_en,
    output logic       win_load,
    output logic       win_en,
    output logic       cpu_clk_en,
    output logic       osc_en,
    output logic [1:0] mode_q,
    output logic       resume_pulse,
    output logic       ram_wr_block,
    output logic       core_rst,
    output pin_mode_e  pin_mode
);
    lpm_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_RUN;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_RUN: begin
                if (hw_rst)                                  nxt = ST_RESET;
                else if (pcon_we && pcon_wdata[MODE_PD_BIT])   nxt = ST_PD;
                else if (pcon_we && pcon_wdata[MODE_IDLE_BIT]) nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (hw_rst)        nxt = ST_RST_WIN;
                else if (any_wake) nxt = ST_RESUME;
            end
            ST_PD: begin
                if (hw_rst)        nxt = ST_RESET;
                else if (ext_wake) nxt = ST_PD_WAKE;
            end
            ST_PD_WAKE: begin
                if (hw_rst)          nxt = ST_RESET;
                else if (osc_stable) nxt = ST_PD_STAB;
            end
            ST_PD_STAB: begin
                if (hw_rst)         nxt = ST_RESET;
                else if (stab_zero) nxt = ST_RESUME;
            end
            ST_RESUME: begin
                if (hw_rst) nxt = ST_RESET;
                else        nxt = ST_RUN;
            end
            ST_RST_WIN: begin
                if (win_zero) nxt = ST_RESET;
            end
            ST_RESET: begin
                if (!hw_rst) nxt = ST_RUN;
            end
            default: nxt = ST_RUN;
        endcase
    end

    always_comb begin
        stab_load    = 1'b0;
        stab_en      = 1'b0;
        win_load     = 1'b0;
        win_en       = 1'b0;
        cpu_clk_en   = 1'b1;
        osc_en       = 1'b1;
        mode_q       = 2'b00;
        resume_pulse = 1'b0;
        ram_wr_block = 1'b0;
        core_rst     = 1'b0;
        pin_mode     = PM_RUN;
        unique case (st)
            ST_RUN: begin
                cpu_clk_en = 1'b1;
            end
            ST_IDLE: begin
                cpu_clk_en            = 1'b0;
                mode_q[MODE_IDLE_BIT] = 1'b1;
                pin_mode              = PM_IDLE;
                win_load              = hw_rst;
            end
            ST_PD: begin
                cpu_clk_en          = 1'b0;
                osc_en              = 1'b0;
                mode_q[MODE_PD_BIT] = 1'b1;
                pin_mode            = PM_PD;
            end
            ST_PD_WAKE: begin
                cpu_clk_en          = 1'b0;
                mode_q[MODE_PD_BIT] = 1'b1;
                pin_mode            = PM_PD;
                stab_load           = osc_stable && !hw_rst;
            end
            ST_PD_STAB: begin
                cpu_clk_en          = 1'b0;
                mode_q[MODE_PD_BIT] = 1'b1;
                pin_mode            = PM_PD;
                stab_en             = 1'b1;
            end
            ST_RESUME: begin
                resume_pulse = 1'b1;
            end
            ST_RST_WIN: begin
                ram_wr_block = 1'b1;
                win_en       = 1'b1;
            end
            ST_RESET: begin
                core_rst = 1'b1;
            end
            default: begin
                core_rst = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int unsigned      N_IRQ    = 5,
    parameter logic [N_IRQ-1:0] EXT_MASK = 5'b00101,
    parameter int unsigned      MC_CLKS  = 12,
    parameter int unsigned      WIN_MC   = 2,
    parameter int unsigned      STAB_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_rst,
    input  logic              pcon_we,
    input  logic [1:0]        pcon_wdata,
    input  logic [N_IRQ-1:0]  irq_pend,
    input  logic [N_IRQ-1:0]  irq_en,
    input  logic              ext_prog,
    input  logic              osc_stable,
    input  logic [STAB_W-1:0] stab_limit,
    input  logic              ram_we_req,
    output logic              ram_we,
    output logic              ram_wr_block,
    output logic              cpu_clk_en,
    output logic              osc_en,
    output logic [1:0]        mode_q,
    output logic              resume_pulse,
    output logic              core_rst,
    output logic              ale_frc,
    output logic              ale_lvl,
    output logic              psen_frc,
    output logic              psen_lvl,
    output logic              p0_float
);
    localparam int unsigned WIN_CLKS = WIN_MC * MC_CLKS;
    localparam int unsigned WIN_W    = $clog2(WIN_CLKS + 1);
    localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(WIN_CLKS - 1);

    lpm_state_e st;
    pin_mode_e  pin_mode;
    logic any_wake, ext_wake;
    logic stab_load, stab_en, stab_zero;
    logic win_load, win_en, win_zero;

    lpm_wake #(.N_IRQ(N_IRQ), .EXT_MASK(EXT_MASK)) u_wake (
        .irq_pend (irq_pend),
        .irq_en   (irq_en),
        .any_wake (any_wake),
        .ext_wake (ext_wake)
    );

    lpm_dncnt #(.W(STAB_W)) u_stab (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (stab_load),
        .load_val (stab_limit),
        .en       (stab_en),
        .zero     (stab_zero)
    );

    lpm_dncnt #(.W(WIN_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (win_load),
        .load_val (WIN_LOAD),
        .en       (win_en),
        .zero     (win_zero)
    );

    lpm_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .hw_rst       (hw_rst),
        .pcon_we      (pcon_we),
        .pcon_wdata   (pcon_wdata),
        .any_wake     (any_wake),
        .ext_wake     (ext_wake),
        .osc_stable   (osc_stable),
        .stab_zero    (stab_zero),
        .win_zero     (win_zero),
        .st           (st),
        .stab_load    (stab_load),
        .stab_en      (stab_en),
        .win_load     (win_load),
        .win_en       (win_en),
        .cpu_clk_en   (cpu_clk_en),
        .osc_en       (osc_en),
        .mode_q       (mode_q),
        .resume_pulse (resume_pulse),
        .ram_wr_block (ram_wr_block),
        .core_rst     (core_rst),
        .pin_mode     (pin_mode)
    );

    lpm_pins u_pins (
        .pin_mode (pin_mode),
        .ext_prog (ext_prog),
        .ale_frc  (ale_frc),
        .ale_lvl  (ale_lvl),
        .psen_frc (psen_frc),
        .psen_lvl (psen_lvl),
        .p0_float (p0_float)
    );

    assign ram_we = ram_we_req & ~ram_wr_block;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk
    import lpm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       hw_rst,
    input logic       pcon_we,
    input logic [1:0] pcon_wdata,
    input lpm_state_e st,
    input logic       ext_wake,
    input logic       cpu_clk_en,
    input logic       osc_en,
    input logic [1:0] mode_q,
    input logic       resume_pulse,
    input logic       ram_we,
    input logic       ram_wr_block,
    input logic       core_rst,
    input logic       ale_frc,
    input logic       ale_lvl,
    input logic       psen_frc,
    input logic       psen_lvl
);
    // R3
    pd_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && !hw_rst && pcon_we && pcon_wdata[1]) |=> (mode_q == 2'b10 && !osc_en));

    // R5
    pd_nonext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PD && !hw_rst && !ext_wake) |=> (mode_q == 2'b10 && !osc_en));

    // R7
    resume_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |=> !resume_pulse);

    // R6
    clk_ungate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk_en) |-> (resume_pulse || core_rst || ram_wr_block));

    // R10
    ram_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_block |-> !ram_we);

    // R10
    win_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_wr_block) |-> core_rst);

    // R8
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b01) |-> (ale_frc && ale_lvl && psen_frc && psen_lvl));

    // R8
    pd_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b10) |-> (ale_frc && !ale_lvl && psen_frc && !psen_lvl && !cpu_clk_en));
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hw_rst       (hw_rst),
    .pcon_we      (pcon_we),
    .pcon_wdata   (pcon_wdata),
    .st           (st),
    .ext_wake     (ext_wake),
    .cpu_clk_en   (cpu_clk_en),
    .osc_en       (osc_en),
    .mode_q       (mode_q),
    .resume_pulse (resume_pulse),
    .ram_we       (ram_we),
    .ram_wr_block (ram_wr_block),
    .core_rst     (core_rst),
    .ale_frc      (ale_frc),
    .ale_lvl      (ale_lvl),
    .psen_frc     (psen_frc),
    .psen_lvl     (psen_lvl)
);

// File: tb/sim_lpm_ctrl.sv
module sim_lpm_ctrl;
    localparam int unsigned N_IRQ   = 5;
    localparam int unsigned MC_CLKS = 3;
    localparam int unsigned WIN     = 2 * MC_CLKS;
    localparam int unsigned STAB_W  = 4;
    localparam int unsigned LIM     = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hw_rst = 1'b0;
    logic pcon_we = 1'b0;
    logic [1:0] pcon_wdata = 2'b00;
    logic [N_IRQ-1:0] irq_pend = '0;
    logic [N_IRQ-1:0] irq_en = '0;
    logic ext_prog = 1'b0;
    logic osc_stable = 1'b0;
    logic [STAB_W-1:0] stab_limit = STAB_W'(LIM);
    logic ram_we_req = 1'b0;
    logic ram_we, ram_wr_block, cpu_clk_en, osc_en, resume_pulse, core_rst;
    logic [1:0] mode_q;
    logic ale_frc, ale_lvl, psen_frc, psen_lvl, p0_float;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lpm_ctrl #(
        .N_IRQ(N_IRQ), .EXT_MASK(5'b00101), .MC_CLKS(MC_CLKS), .WIN_MC(2), .STAB_W(STAB_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst), .pcon_we(pcon_we), .pcon_wdata(pcon_wdata),
        .irq_pend(irq_pend), .irq_en(irq_en), .ext_prog(ext_prog), .osc_stable(osc_stable),
        .stab_limit(stab_limit), .ram_we_req(ram_we_req), .ram_we(ram_we),
        .ram_wr_block(ram_wr_block), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .mode_q(mode_q),
        .resume_pulse(resume_pulse), .core_rst(core_rst), .ale_frc(ale_frc), .ale_lvl(ale_lvl),
        .psen_frc(psen_frc), .psen_lvl(psen_lvl), .p0_float(p0_float)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_mode(input logic [1:0] v);
        pcon_we = 1'b1;
        pcon_wdata = v;
        tick();
        pcon_we = 1'b0;
        pcon_wdata = 2'b00;
    endtask

    function automatic logic [31:0] pins();
        return {27'd0, ale_frc, ale_lvl, psen_frc, psen_lvl, p0_float};
    endfunction

    task automatic t_reset();
        chk("R1 clk_en", cpu_clk_en, 1);
        chk("R1 osc_en", osc_en, 1);
        chk("R1 mode", mode_q, 0);
        chk("R1 core_rst/resume", {core_rst, resume_pulse}, 0);
        chk("R1 pins", pins(), 0);
    endtask

    task automatic t_idle_wake();
        ext_prog = 1'b1;
        write_mode(2'b01);
        chk("R2 clk_en", cpu_clk_en, 0);
        chk("R2 osc_en", osc_en, 1);
        chk("R2 mode", mode_q, 2'b01);
        chk("R8 idle pins", pins() >> 1, 4'b1111);
        chk("R9 idle p0 ext", p0_float, 1);
        ext_prog = 1'b0;
        #1;
        chk("R9 idle p0 int", p0_float, 0);
        irq_pend = 5'b00010;
        irq_en = 5'b00000;
        tick();
        chk("R4 disabled ignored", mode_q, 2'b01);
        irq_en = 5'b00010;
        tick();
        chk("R7 resume", {resume_pulse, cpu_clk_en, mode_q}, 4'b1100);
        tick();
        chk("R7 single pulse", resume_pulse, 0);
        chk("R8 run pins", pins(), 0);
        irq_pend = '0;
        irq_en = '0;
    endtask

    task automatic t_pd_wake();
        int n;
        ext_prog = 1'b1;
        write_mode(2'b11);
        chk("R3 mode", mode_q, 2'b10);
        chk("R3 clocks", {cpu_clk_en, osc_en}, 0);
        chk("R8 pd pins", pins() >> 1, 4'b1010);
        chk("R9 pd p0", p0_float, 1);
        irq_en = 5'b11111;
        irq_pend = 5'b00010;
        tick();
        tick();
        chk("R5 nonext ignored", {osc_en, mode_q}, 3'b010);
        irq_pend = 5'b00100;
        tick();
        chk("R6 osc on", {osc_en, cpu_clk_en}, 2'b10);
        irq_pend = '0;
        tick();
        tick();
        chk("R6 gated until stable", cpu_clk_en, 0);
        osc_stable = 1'b1;
        n = 0;
        for (int k = 0; k < 40; k++) begin
            tick();
            n++;
            if (resume_pulse) break;
            if (cpu_clk_en) chk("R6 early ungate", cpu_clk_en, 0);
        end
        chk("R6 settle edges", n, LIM + 2);
        chk("R7 pd resume", {resume_pulse, cpu_clk_en, mode_q}, 4'b1100);
        tick();
        chk("R7 pd single pulse", resume_pulse, 0);
        osc_stable = 1'b0;
        irq_en = '0;
        ext_prog = 1'b0;
    endtask

    task automatic t_idle_reset();
        int n;
        write_mode(2'b01);
        hw_rst = 1'b1;
        ram_we_req = 1'b1;
        tick();
        chk("R10 window entry", {ram_wr_block, ram_we, cpu_clk_en, core_rst}, 4'b1010);
        chk("R10 mode cleared", mode_q, 0);
        n = 1;
        for (int k = 0; k < 40; k++) begin
            tick();
            if (!ram_wr_block) break;
            n++;
        end
        chk("R10 window length", n, WIN);
        chk("R10 handover", {core_rst, ram_we}, 2'b11);
        hw_rst = 1'b0;
        ram_we_req = 1'b0;
        tick();
        chk("R11 release", {core_rst, cpu_clk_en}, 2'b01);
    endtask

    task automatic t_pd_reset();
        write_mode(2'b10);
        chk("R3 pd entered", osc_en, 0);
        hw_rst = 1'b1;
        tick();
        chk("R11 pd reset", {core_rst, osc_en, ram_wr_block, mode_q}, 5'b11000);
        tick();
        chk("R11 held", core_rst, 1);
        hw_rst = 1'b0;
        tick();
        chk("R11 back to run", {core_rst, mode_q}, 3'b000);
        hw_rst = 1'b1;
        tick();
        chk("R11 run reset", {core_rst, ram_wr_block}, 2'b10);
        hw_rst = 1'b0;
        tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_wake();
        t_pd_wake();
        t_idle_reset();
        t_pd_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule